// File: doc/BRIEF.md
# String Move Address Sequencer

This block walks a block copy between two memory regions for a 16-bit segmented processor. A start strobe captures the starting source and destination offsets, a repeat count, the two segment bases, the element size (byte or word), the repeat flag and the direction bit. For each element, the block first raises a read request at the source physical address. In the next cycle it raises a write request at the destination physical address. It then steps both offsets and, when repeating, lowers the count. The sequence ends when the count runs out. A single-cycle done pulse closes the operation.

A physical address is the 16-bit segment base shifted left by four, plus the 16-bit offset, kept to 20 bits. The source is formed on the data segment base and the destination on the extra segment base. Memory itself is outside the block: each request lasts exactly one cycle, and the access is taken to complete in that cycle.

Top module: `str_addr_seq`

## Requirements
- R1: After reset, rd_req_o, wr_req_o, done_o and busy_o are 0, and si_o, di_o and cnt_o are 0.
- R2: While rd_req_o is 1, rd_addr_o equals (src_seg_i << 4) + current source offset, modulo 2^20, using the base captured at start.
- R3: While wr_req_o is 1, wr_addr_o equals (dst_seg_i << 4) + current destination offset, modulo 2^20, using the base captured at start.
- R4: After each element's write, both offsets increase when dir_i was 0 at start and decrease when it was 1.
- R5: The offset step is 1 when word_i was 0 at start (byte) and 2 when it was 1 (word).
- R6: With rep_i = 1 and a nonzero count, exactly cnt_init_i elements are moved, cnt_o drops by 1 after each write, and it ends at 0.
- R7: With rep_i = 1 and cnt_init_i = 0, no read or write request is raised and done_o is 1 in the cycle after the start edge.
- R8: With rep_i = 0, exactly one element is moved whatever the count, and cnt_o keeps cnt_init_i.
- R9: Offsets wrap modulo 2^16. A segment base of FFFFh plus an offset wraps modulo 2^20.
- R10: Element k (counted from 0) reads in cycle 2k+1 and writes in cycle 2k+2 after the accepting edge, with the read and write requests never both high. done_o is a one-cycle pulse in cycle 2N+1, where N is the element count.
- R11: start_i and all initial-value inputs are ignored while busy_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation (taken only when idle) |
| word_i | input | 1 | Element size: 0 byte, 1 word |
| rep_i | input | 1 | Repeat by count |
| dir_i | input | 1 | 0 step up, 1 step down |
| si_init_i | input | 16 | Initial source offset |
| di_init_i | input | 16 | Initial destination offset |
| cnt_init_i | input | 16 | Initial repeat count |
| src_seg_i | input | 16 | Source (data) segment base |
| dst_seg_i | input | 16 | Destination (extra) segment base |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | 20 | Read physical address |
| wr_req_o | output | 1 | Write request |
| wr_addr_o | output | 20 | Write physical address |
| si_o | output | 16 | Current source offset |
| di_o | output | 16 | Current destination offset |
| cnt_o | output | 16 | Current count |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Counting the accepting edge as cycle 0, element k's read is due in cycle 2k+1 and its write in cycle 2k+2. The done pulse is due in cycle 2N+1, or in cycle 1 when the repeat count is zero. The final offsets, the final count and the return to idle are due in cycle 2N+2. The bench samples at each falling edge after the start. At every such sample it compares both request lines, both addresses and done against values computed for that cycle number. It then checks the final register values one cycle after the pulse.

// File: rtl/str_seq_pkg.sv
package str_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2,
    ST_DONE = 2'd3
  } seq_state_e;

  localparam int unsigned NUM_CH = 2;
  localparam int unsigned CH_SRC = 0;
  localparam int unsigned CH_DST = 1;
endpackage

// File: rtl/str_phys_addr.sv
module str_phys_addr #(
  parameter int unsigned OFS_W     = 16,
  parameter int unsigned SEG_SHIFT = 4,
  localparam int unsigned ADDR_W   = OFS_W + SEG_SHIFT
) (
  input  logic [OFS_W-1:0]  seg_i,
  input  logic [OFS_W-1:0]  ofs_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] seg_ext;
  logic [ADDR_W-1:0] ofs_ext;

  assign seg_ext = {seg_i, {SEG_SHIFT{1'b0}}};
  assign ofs_ext = {{SEG_SHIFT{1'b0}}, ofs_i};
  assign addr_o  = seg_ext + ofs_ext;
endmodule

// File: rtl/str_idx_unit.sv
module str_idx_unit #(
  parameter int unsigned OFS_W      = 16,
  parameter int unsigned WORD_BYTES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [OFS_W-1:0] init_i,
  input  logic             step_i,
  input  logic             word_i,
  input  logic             dir_i,
  output logic [OFS_W-1:0] idx_o
);
  logic [OFS_W-1:0] amt;
  logic [OFS_W-1:0] idx_q;
  logic [OFS_W-1:0] idx_nxt;

  assign amt = word_i ? OFS_W'(WORD_BYTES) : OFS_W'(1);

  // modulo 2^OFS_W wrap falls out of the fixed width
  always_comb begin
    idx_nxt = idx_q;
    if (load_i)      idx_nxt = init_i;
    else if (step_i) idx_nxt = dir_i ? (idx_q - amt) : (idx_q + amt);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idx_q <= '0;
    else         idx_q <= idx_nxt;
  end

  assign idx_o = idx_q;
endmodule

// File: rtl/str_cnt_unit.sv
module str_cnt_unit #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] init_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= init_i;
    else if (dec_i)  cnt_q <= cnt_q - CNT_W'(1);
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/str_addr_seq.sv
module str_addr_seq
  import str_seq_pkg::*;
#(
  parameter int unsigned OFS_W      = 16,
  parameter int unsigned SEG_SHIFT  = 4,
  parameter int unsigned WORD_BYTES = 2,
  parameter int unsigned CNT_W      = 16,
  localparam int unsigned ADDR_W    = OFS_W + SEG_SHIFT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              word_i,
  input  logic              rep_i,
  input  logic              dir_i,
  input  logic [OFS_W-1:0]  si_init_i,
  input  logic [OFS_W-1:0]  di_init_i,
  input  logic [CNT_W-1:0]  cnt_init_i,
  input  logic [OFS_W-1:0]  src_seg_i,
  input  logic [OFS_W-1:0]  dst_seg_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              wr_req_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [OFS_W-1:0]  si_o,
  output logic [OFS_W-1:0]  di_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              busy_o,
  output logic              done_o
);
  seq_state_e state_q, state_d;
  logic word_q, dir_q, rep_q;
  logic [OFS_W-1:0] src_seg_q, dst_seg_q;
  logic accept, step_en, cnt_last;

  logic [OFS_W-1:0]  idx_init [NUM_CH];
  logic [OFS_W-1:0]  idx_cur  [NUM_CH];
  logic [OFS_W-1:0]  seg_cur  [NUM_CH];
  logic [ADDR_W-1:0] addr_cur [NUM_CH];

  assign accept  = (state_q == ST_IDLE) && start_i;
  assign step_en = (state_q == ST_WR);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = (rep_i && (cnt_init_i == '0)) ? ST_DONE : ST_RD;
      ST_RD:   state_d = ST_WR;
      ST_WR:   state_d = (!rep_q || cnt_last) ? ST_DONE : ST_RD;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      word_q    <= 1'b0;
      dir_q     <= 1'b0;
      rep_q     <= 1'b0;
      src_seg_q <= '0;
      dst_seg_q <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        word_q    <= word_i;
        dir_q     <= dir_i;
        rep_q     <= rep_i;
        src_seg_q <= src_seg_i;
        dst_seg_q <= dst_seg_i;
      end
    end
  end

  assign idx_init[CH_SRC] = si_init_i;
  assign idx_init[CH_DST] = di_init_i;
  assign seg_cur[CH_SRC]  = src_seg_q;
  assign seg_cur[CH_DST]  = dst_seg_q;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    str_idx_unit #(
      .OFS_W     (OFS_W),
      .WORD_BYTES(WORD_BYTES)
    ) u_idx (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .load_i(accept),
      .init_i(idx_init[g]),
      .step_i(step_en),
      .word_i(word_q),
      .dir_i (dir_q),
      .idx_o (idx_cur[g])
    );

    str_phys_addr #(
      .OFS_W    (OFS_W),
      .SEG_SHIFT(SEG_SHIFT)
    ) u_pa (
      .seg_i (seg_cur[g]),
      .ofs_i (idx_cur[g]),
      .addr_o(addr_cur[g])
    );
  end

  str_cnt_unit #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(accept),
    .init_i(cnt_init_i),
    .dec_i (step_en && rep_q),
    .cnt_o (cnt_o),
    .last_o(cnt_last)
  );

  assign rd_req_o  = (state_q == ST_RD);
  assign wr_req_o  = (state_q == ST_WR);
  assign done_o    = (state_q == ST_DONE);
  assign busy_o    = (state_q != ST_IDLE);
  assign rd_addr_o = addr_cur[CH_SRC];
  assign wr_addr_o = addr_cur[CH_DST];
  assign si_o      = idx_cur[CH_SRC];
  assign di_o      = idx_cur[CH_DST];
endmodule

// File: rtl/str_addr_seq_chk.sv
module str_addr_seq_chk #(
  parameter int unsigned OFS_W      = 16,
  parameter int unsigned SEG_SHIFT  = 4,
  parameter int unsigned WORD_BYTES = 2,
  parameter int unsigned CNT_W      = 16,
  localparam int unsigned ADDR_W    = OFS_W + SEG_SHIFT
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_req_o,
  input logic              wr_req_o,
  input logic              done_o,
  input logic              busy_o,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic [OFS_W-1:0]  si_o,
  input logic [OFS_W-1:0]  di_o,
  input logic [CNT_W-1:0]  cnt_o,
  input logic [OFS_W-1:0]  src_seg_q,
  input logic [OFS_W-1:0]  dst_seg_q,
  input logic              rep_q,
  input logic              dir_q,
  input logic              word_q
);
  logic [OFS_W-1:0] amt;
  assign amt = word_q ? OFS_W'(WORD_BYTES) : OFS_W'(1);

  assert_rd_addr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> rd_addr_o == ((ADDR_W'(src_seg_q) << SEG_SHIFT) + ADDR_W'(si_o)));

  assert_wr_addr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |-> wr_addr_o == ((ADDR_W'(dst_seg_q) << SEG_SHIFT) + ADDR_W'(di_o)));

  assert_idx_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |=> si_o == ($past(dir_q) ? $past(si_o) - $past(amt) : $past(si_o) + $past(amt)));

  assert_cnt_dec_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_o && rep_q) |=> cnt_o == $past(cnt_o) - CNT_W'(1));

  assert_no_rd_at_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && rep_q) |-> cnt_o != '0);

  assert_cnt_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_o && !rep_q) |=> $stable(cnt_o));

  assert_req_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_req_o && wr_req_o));

  assert_rd_then_wr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |=> wr_req_o);

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_seg_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ($stable(src_seg_q) && $stable(dst_seg_q) && $stable(rep_q)));
endmodule

bind str_addr_seq str_addr_seq_chk #(
  .OFS_W     (OFS_W),
  .SEG_SHIFT (SEG_SHIFT),
  .WORD_BYTES(WORD_BYTES),
  .CNT_W     (CNT_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .rd_req_o (rd_req_o),
  .wr_req_o (wr_req_o),
  .done_o   (done_o),
  .busy_o   (busy_o),
  .rd_addr_o(rd_addr_o),
  .wr_addr_o(wr_addr_o),
  .si_o     (si_o),
  .di_o     (di_o),
  .cnt_o    (cnt_o),
  .src_seg_q(src_seg_q),
  .dst_seg_q(dst_seg_q),
  .rep_q    (rep_q),
  .dir_q    (dir_q),
  .word_q   (word_q)
);

// File: tb/str_addr_seq_tb_top.sv
module str_addr_seq_tb_top;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, word_i = 1'b0, rep_i = 1'b0, dir_i = 1'b0;
  logic [15:0] si_init_i = '0, di_init_i = '0, cnt_init_i = '0;
  logic [15:0] src_seg_i = '0, dst_seg_i = '0;
  logic rd_req_o, wr_req_o, busy_o, done_o;
  logic [19:0] rd_addr_o, wr_addr_o;
  logic [15:0] si_o, di_o, cnt_o;

  int checks = 0;
  int errors = 0;

  always #2 clk_i = ~clk_i;

  str_addr_seq dut_i (
    .clk_i, .rst_ni, .start_i, .word_i, .rep_i, .dir_i,
    .si_init_i, .di_init_i, .cnt_init_i, .src_seg_i, .dst_seg_i,
    .rd_req_o, .rd_addr_o, .wr_req_o, .wr_addr_o,
    .si_o, .di_o, .cnt_o, .busy_o, .done_o
  );

  function automatic logic [19:0] phys(input logic [15:0] seg, input logic [15:0] ofs);
    return {seg, 4'h0} + {4'h0, ofs};
  endfunction

  function automatic logic [15:0] ofs_at(input logic [15:0] base, input int k,
                                         input bit word, input bit dir);
    logic [15:0] d;
    d = 16'(k * (word ? 2 : 1));
    return dir ? base - d : base + d;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [15:0] si, di, cnt, ds, es,
                        input bit word, dir, rep, poke);
    int n;
    n = rep ? int'(cnt) : 1;
    @(negedge clk_i);
    si_init_i = si; di_init_i = di; cnt_init_i = cnt;
    src_seg_i = ds; dst_seg_i = es;
    word_i = word; dir_i = dir; rep_i = rep; start_i = 1'b1;
    for (int c = 1; c <= 2 * n + 2; c++) begin
      @(negedge clk_i);
      if (c <= 2 * n + 1) begin
        bit exp_rd, exp_wr, exp_done;
        int k;
        exp_rd   = (c <= 2 * n) && (c % 2 == 1);
        exp_wr   = (c <= 2 * n) && (c % 2 == 0);
        exp_done = (c == 2 * n + 1);
        k = (c - 1) / 2;
        chk("R10", "rd_req", 32'(rd_req_o), 32'(exp_rd));
        chk("R10", "wr_req", 32'(wr_req_o), 32'(exp_wr));
        chk("R10", "done", 32'(done_o), 32'(exp_done));
        if (exp_rd) chk("R2", "rd_addr", 32'(rd_addr_o), 32'(phys(ds, ofs_at(si, k, word, dir))));
        if (exp_wr) chk("R3", "wr_addr", 32'(wr_addr_o), 32'(phys(es, ofs_at(di, k, word, dir))));
        if (poke && c < 2 * n + 1) begin
          // R11: scramble inputs while busy
          start_i = 1'b1;
          si_init_i = 16'($urandom); di_init_i = 16'($urandom);
          cnt_init_i = 16'($urandom); src_seg_i = 16'($urandom);
          dst_seg_i = 16'($urandom); word_i = ~word; dir_i = ~dir; rep_i = ~rep;
        end else begin
          start_i = 1'b0;
        end
      end else begin
        chk("R10", "busy_after", 32'(busy_o), 32'd0);
        chk("R10", "done_after", 32'(done_o), 32'd0);
        chk("R4_R5_R9", "si_final", 32'(si_o), 32'(ofs_at(si, n, word, dir)));
        chk("R4_R5_R9", "di_final", 32'(di_o), 32'(ofs_at(di, n, word, dir)));
        chk(rep ? "R6" : "R8", "cnt_final", 32'(cnt_o), rep ? 32'd0 : 32'(cnt));
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1", "rd_req", 32'(rd_req_o), 32'd0);
    chk("R1", "wr_req", 32'(wr_req_o), 32'd0);
    chk("R1", "done", 32'(done_o), 32'd0);
    chk("R1", "busy", 32'(busy_o), 32'd0);
    chk("R1", "regs", {si_o, di_o}, 32'd0);
    chk("R1", "cnt", 32'(cnt_o), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    run_op(16'h0100, 16'h0200, 16'd4, 16'h1000, 16'h2000, 1'b0, 1'b0, 1'b1, 1'b0); // R4 R5 byte up
    run_op(16'h0100, 16'h0200, 16'd5, 16'h1000, 16'h2000, 1'b1, 1'b1, 1'b1, 1'b0); // R4 R5 word down
    run_op(16'hFFFE, 16'h0001, 16'd3, 16'h0000, 16'h0000, 1'b1, 1'b0, 1'b1, 1'b0); // R9 wrap up
    run_op(16'h0001, 16'h0000, 16'd3, 16'h0040, 16'h0040, 1'b1, 1'b1, 1'b1, 1'b0); // R9 wrap down
    run_op(16'h0020, 16'hFFF0, 16'd2, 16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 1'b1, 1'b0); // R9 20-bit wrap
    run_op(16'h1234, 16'h5678, 16'd0, 16'h0100, 16'h0200, 1'b1, 1'b0, 1'b1, 1'b0); // R7 zero count
    run_op(16'h1234, 16'h5678, 16'd9, 16'h0100, 16'h0200, 1'b1, 1'b0, 1'b0, 1'b0); // R8 single
    run_op(16'h1234, 16'h5678, 16'd0, 16'h0100, 16'h0200, 1'b0, 1'b1, 1'b0, 1'b0); // R8 count 0
    run_op(16'h0300, 16'h0400, 16'd6, 16'h3000, 16'h4000, 1'b1, 1'b0, 1'b1, 1'b1); // R11 poke
    run_op(16'h0300, 16'h0400, 16'd0, 16'h3000, 16'h4000, 1'b0, 1'b0, 1'b1, 1'b1); // R11 R7 poke
    for (int i = 0; i < 60; i++) begin
      run_op(16'($urandom), 16'($urandom), 16'($urandom_range(0, 30)),
             16'($urandom), 16'($urandom), 1'($urandom), 1'($urandom),
             ($urandom_range(0, 3) != 0), 1'($urandom)); // R6 random
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule